// File: doc/BRIEF.md
# PCI Configuration Register File with One I/O Window

This block is the byte-wide configuration register file of a single-function PCI device that claims one 32-byte I/O window. A configuration master presents a byte offset, write data and a write strobe. The block answers reads combinationally with the byte at that offset. It holds a two-bit command register, one I/O base address register, an interrupt line byte and a fixed interrupt pin byte. The device and subsystem identity bytes are constants.

From the command register and the base register the block derives the current I/O base and an I/O decode enable. It also compares an incoming 16-bit I/O address against that base, so the device's register window knows when it is addressed. Decoding of configuration cycles on the bus is done elsewhere. This block only sees the byte port.

Top module: `pci_cfg_iobar`

## Requirements
- R1: Reads at offsets 0x00, 0x01, 0x02, 0x03 return 0x1A, 0x07, 0x0B, 0xAB (vendor 0x071A, device 0xAB0B, little-endian), and writes there change nothing.
- R2: Reads at offsets 0x2C, 0x2D, 0x2E, 0x2F return the same four bytes 0x1A, 0x07, 0x0B, 0xAB as subsystem vendor and subsystem device.
- R3: Offset 0x04 holds the command; after reset it reads 0x03, and a write stores only data bits 1:0, with bits 7:2 reading 0. Bit 0 is the I/O space enable. Offset 0x05 reads 0.
- R4: A write to offset 0x10 stores data bits 7:5 only. Reads of 0x10 always show bit 0 as 1 and bits 4:1 as 0.
- R5: Writes to offsets 0x11, 0x12, 0x13 store all eight bits into base bits 15:8, 23:16, 31:24. After reset the base register reads 0x00000001.
- R6: `io_base` equals the 32-bit base register with bits 4:0 cleared. `io_decode_en` is 1 exactly when command bit 0 is 1 and `io_base` is nonzero.
- R7: Offset 0x3C is a read/write interrupt line byte that resets to 0x00. Offset 0x3D reads 0x04 (pin D) and ignores writes.
- R8: Offsets 0x06 to 0x0B and every offset not named above read 0x00, and writes to them change no readable byte or output.
- R9: `io_hit` is 1 exactly when `io_decode_en` is 1 and `io_addr[15:5]` equals `io_base[15:5]`.
- R10: A write takes effect at the clock edge that samples the strobe. In that cycle reads and outputs still show the old value; from the next cycle they show the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| io_addr | input | 16 | Incoming I/O address to match |
| io_base | output | 32 | Current I/O base, 32-byte aligned |
| io_decode_en | output | 1 | I/O window decode enable |
| io_hit | output | 1 | `io_addr` falls in the enabled window |

## Verification
On every cycle the assertions check the constant identity and pin bytes, the fixed bits of the base byte at 0x10, and the link between hit, decode enable and a nonzero base. They also check that the base only moves after a write strobe, and that clearing the I/O enable bit turns decoding off in the next cycle. The exact stored values need the bench's directed scenarios. These are the two-bit command masking, the 0xE0 mask on the low base byte, full-byte storage in the upper base bytes, interrupt line storage, and ignored writes to read-only and unimplemented offsets. The bench also covers the window edges at offsets 0 and 31, and the case where the enable is set but the base is zero.

// File: rtl/pci_cfg_iobar_pkg.sv
// Package: shared offsets and the read-source selection for the
// configuration register file. Assumes an 8-bit byte offset.
package pci_cfg_iobar_pkg;

    localparam logic [7:0] OFS_CMD_LO  = 8'h04;
    localparam logic [7:0] OFS_BAR_B0  = 8'h10;
    localparam logic [7:0] OFS_ILINE   = 8'h3C;
    localparam logic [7:0] OFS_IPIN    = 8'h3D;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_IDENT,
        SEL_SUBSYS,
        SEL_CMD,
        SEL_BAR,
        SEL_ILINE,
        SEL_IPIN
    } rd_sel_e;

    // Map a byte offset to the source that answers it.
    function automatic rd_sel_e offset_to_sel(input logic [7:0] ofs);
        rd_sel_e s;
        if (ofs[7:2] == 6'h00)           s = SEL_IDENT;
        else if (ofs[7:2] == 6'h0B)      s = SEL_SUBSYS;
        else if (ofs[7:2] == 6'h04)      s = SEL_BAR;
        else if (ofs == OFS_CMD_LO)      s = SEL_CMD;
        else if (ofs == OFS_ILINE)       s = SEL_ILINE;
        else if (ofs == OFS_IPIN)        s = SEL_IPIN;
        else                             s = SEL_ZERO;
        return s;
    endfunction

endpackage

// File: rtl/pci_cfg_iobar_cmd.sv
// Command register: keeps only the low CMD_BITS bits of a write.
// Assumes the caller qualifies the strobe with the command offset.
module pci_cfg_iobar_cmd #(
    parameter int               CMD_BITS = 2,
    parameter logic [CMD_BITS-1:0] RST_VAL = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [CMD_BITS-1:0] wr_bits,
    output logic [CMD_BITS-1:0] cmd
);

    // Store the masked command bits on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd <= RST_VAL;
        else if (wr_stb) cmd <= wr_bits;
    end

endmodule

// File: rtl/pci_cfg_iobar_bar.sv
// I/O base register, one byte lane per generate branch. The lowest
// lane drops the bits below ALIGN_BITS and forces the I/O flag bit 0.
// Assumes the caller qualifies the strobe with the register's offsets.
module pci_cfg_iobar_bar #(
    parameter int ALIGN_BITS = 5,
    parameter int BAR_BYTES  = 4,
    localparam int BAR_W     = 8 * BAR_BYTES,
    localparam int LANE_W    = $clog2(BAR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        wdata,
    output logic [BAR_W-1:0]  bar
);

    localparam logic [7:0] LOW_KEEP = 8'hFF << ALIGN_BITS;

    for (genvar g = 0; g < BAR_BYTES; g++) begin : g_lane
        if (g == 0) begin : g_low
            // Lowest lane: aligned bits only, I/O flag forced high.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bar[7:0] <= 8'h01;
                else if (wr_stb && lane == LANE_W'(g))
                    bar[7:0] <= (wdata & LOW_KEEP) | 8'h01;
            end
        end else begin : g_high
            // Upper lanes: whole byte stored.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bar[8*g +: 8] <= 8'h00;
                else if (wr_stb && lane == LANE_W'(g))
                    bar[8*g +: 8] <= wdata;
            end
        end
    end

endmodule

// File: rtl/pci_cfg_iobar_decode.sv
// I/O window decode: aligned base, enable and address match.
// Purely combinational; assumes IO_AW <= BAR_W.
module pci_cfg_iobar_decode #(
    parameter int IO_AW      = 16,
    parameter int ALIGN_BITS = 5,
    parameter int BAR_W      = 32
) (
    input  logic [BAR_W-1:0] bar,
    input  logic             io_space_en,
    input  logic [IO_AW-1:0] io_addr,
    output logic [BAR_W-1:0] io_base,
    output logic             decode_en,
    output logic             hit
);

    localparam logic [BAR_W-1:0] BASE_MASK = {BAR_W{1'b1}} << ALIGN_BITS;
    localparam logic [IO_AW-1:0] ADDR_MASK = {IO_AW{1'b1}} << ALIGN_BITS;

    // Derive base, enable and window match.
    always_comb begin
        io_base   = bar & BASE_MASK;
        decode_en = io_space_en && (io_base != '0);
        hit       = decode_en && ((io_addr & ADDR_MASK) == io_base[IO_AW-1:0]);
    end

endmodule

// File: rtl/pci_cfg_iobar.sv
// Configuration register file of a single-function device with one
// I/O window. Reads are combinational; writes land at the clock edge.
// Assumes a decoded byte-wide configuration port.
module pci_cfg_iobar
    import pci_cfg_iobar_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h071A,
    parameter logic [15:0] DEVICE_ID     = 16'hAB0B,
    parameter logic [15:0] SUB_VENDOR_ID = 16'h071A,
    parameter logic [15:0] SUB_DEVICE_ID = 16'hAB0B,
    parameter logic [7:0]  INT_PIN       = 8'h04,
    parameter int          IO_AW         = 16,
    parameter int          ALIGN_BITS    = 5,
    parameter int          CMD_BITS      = 2,
    localparam int         BAR_W         = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic [IO_AW-1:0] io_addr,
    output logic [BAR_W-1:0] io_base,
    output logic             io_decode_en,
    output logic             io_hit
);

    localparam logic [31:0] IDENT_WORD  = {DEVICE_ID, VENDOR_ID};
    localparam logic [31:0] SUBSYS_WORD = {SUB_DEVICE_ID, SUB_VENDOR_ID};

    rd_sel_e               sel;
    logic [CMD_BITS-1:0]   cmd;
    logic [BAR_W-1:0]      bar;
    logic [7:0]            int_line;

    assign sel = offset_to_sel(cfg_addr);

    pci_cfg_iobar_cmd #(
        .CMD_BITS (CMD_BITS),
        .RST_VAL  ({CMD_BITS{1'b1}})
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (cfg_wr_en && sel == SEL_CMD),
        .wr_bits (cfg_wdata[CMD_BITS-1:0]),
        .cmd     (cmd)
    );

    pci_cfg_iobar_bar #(
        .ALIGN_BITS (ALIGN_BITS),
        .BAR_BYTES  (BAR_W / 8)
    ) u_bar (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (cfg_wr_en && sel == SEL_BAR),
        .lane   (cfg_addr[1:0]),
        .wdata  (cfg_wdata),
        .bar    (bar)
    );

    pci_cfg_iobar_decode #(
        .IO_AW      (IO_AW),
        .ALIGN_BITS (ALIGN_BITS),
        .BAR_W      (BAR_W)
    ) u_dec (
        .bar         (bar),
        .io_space_en (cmd[0]),
        .io_addr     (io_addr),
        .io_base     (io_base),
        .decode_en   (io_decode_en),
        .hit         (io_hit)
    );

    // Interrupt line byte: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                              int_line <= 8'h00;
        else if (cfg_wr_en && sel == SEL_ILINE)  int_line <= cfg_wdata;
    end

    // Read multiplexer over all configuration sources.
    always_comb begin
        unique case (sel)
            SEL_IDENT:  cfg_rdata = IDENT_WORD[8*cfg_addr[1:0] +: 8];
            SEL_SUBSYS: cfg_rdata = SUBSYS_WORD[8*cfg_addr[1:0] +: 8];
            SEL_CMD:    cfg_rdata = 8'(cmd);
            SEL_BAR:    cfg_rdata = bar[8*cfg_addr[1:0] +: 8];
            SEL_ILINE:  cfg_rdata = int_line;
            SEL_IPIN:   cfg_rdata = INT_PIN;
            default:    cfg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/pci_cfg_iobar_chk.sv
// Checker for pci_cfg_iobar, attached by bind. Watches ports only.
module pci_cfg_iobar_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [7:0]  cfg_addr,
    input logic [7:0]  cfg_wdata,
    input logic [7:0]  cfg_rdata,
    input logic [15:0] io_addr,
    input logic [31:0] io_base,
    input logic        io_decode_en,
    input logic        io_hit
);

    AST_VENDOR_LO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr == 8'h00 |-> cfg_rdata == 8'h1A); // R1

    AST_SUBSYS_HI_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr == 8'h2F |-> cfg_rdata == 8'hAB); // R2

    AST_BAR_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr == 8'h10 |-> (cfg_rdata[4:0] == 5'b00001)); // R4

    AST_DECODE_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        io_decode_en |-> io_base != 32'h0); // R6

    AST_PIN_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr == 8'h3D |-> cfg_rdata == 8'h04); // R7

    AST_HIT_NEEDS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (io_decode_en && io_addr[15:5] == io_base[15:5])); // R9

    AST_IO_OFF_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == 8'h04 && !cfg_wdata[0]) |=> !io_decode_en); // R3

    AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_wr_en)) |-> $stable(io_base)); // R10

endmodule

bind pci_cfg_iobar pci_cfg_iobar_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .io_addr      (io_addr),
    .io_base      (io_base),
    .io_decode_en (io_decode_en),
    .io_hit       (io_hit)
);

// File: tb/pci_cfg_iobar_tb_top.sv
`timescale 1ns/1ps
module pci_cfg_iobar_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_addr = 16'h0000;
    logic [31:0] io_base;
    logic        io_decode_en;
    logic        io_hit;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pci_cfg_iobar dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .io_addr      (io_addr),
        .io_base      (io_base),
        .io_decode_en (io_decode_en),
        .io_hit       (io_hit)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic read_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
        cfg_addr = a;
        #1;
        check(cfg_rdata === e, tag, 32'(cfg_rdata), 32'(e));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        read_expect(8'h04, 8'h03, "R3 command reset");
        read_expect(8'h10, 8'h01, "R5 base byte0 reset");
        read_expect(8'h11, 8'h00, "R5 base byte1 reset");
        read_expect(8'h3C, 8'h00, "R7 line reset");
        check(io_base === 32'h0, "R6 base reset", io_base, 32'h0);
        check(io_decode_en === 1'b0, "R6 decode off at zero base", 32'(io_decode_en), 0);
    endtask

    task automatic t_identity();
        cfg_write(8'h00, 8'hFF);
        cfg_write(8'h2E, 8'h55);
        read_expect(8'h00, 8'h1A, "R1 id0");
        read_expect(8'h01, 8'h07, "R1 id1");
        read_expect(8'h02, 8'h0B, "R1 id2");
        read_expect(8'h03, 8'hAB, "R1 id3");
        read_expect(8'h2C, 8'h1A, "R2 sub0");
        read_expect(8'h2D, 8'h07, "R2 sub1");
        read_expect(8'h2E, 8'h0B, "R2 sub2");
        read_expect(8'h2F, 8'hAB, "R2 sub3");
    endtask

    task automatic t_command();
        cfg_write(8'h04, 8'hFE);
        read_expect(8'h04, 8'h02, "R3 masked write FE");
        cfg_write(8'h04, 8'h05);
        read_expect(8'h04, 8'h01, "R3 masked write 05");
        cfg_write(8'h05, 8'hFF);
        read_expect(8'h05, 8'h00, "R3 high byte zero");
    endtask

    task automatic t_bar_bytes();
        cfg_write(8'h10, 8'hFF);
        read_expect(8'h10, 8'hE1, "R4 low byte FF");
        cfg_write(8'h10, 8'h3E);
        read_expect(8'h10, 8'h21, "R4 low byte 3E");
        cfg_write(8'h11, 8'h5A);
        cfg_write(8'h12, 8'hC3);
        cfg_write(8'h13, 8'h81);
        read_expect(8'h11, 8'h5A, "R5 byte1");
        read_expect(8'h12, 8'hC3, "R5 byte2");
        read_expect(8'h13, 8'h81, "R5 byte3");
        check(io_base === 32'h81C35A20, "R6 base value", io_base, 32'h81C35A20);
    endtask

    task automatic t_decode();
        cfg_write(8'h04, 8'h00);
        check(io_decode_en === 1'b0, "R6 off with io bit clear", 32'(io_decode_en), 0);
        cfg_write(8'h04, 8'h01);
        check(io_decode_en === 1'b1, "R6 on with base nonzero", 32'(io_decode_en), 1);
        cfg_write(8'h10, 8'h00); cfg_write(8'h11, 8'h00);
        cfg_write(8'h12, 8'h00); cfg_write(8'h13, 8'h00);
        check(io_decode_en === 1'b0, "R6 off with zero base", 32'(io_decode_en), 0);
        cfg_write(8'h13, 8'h01);
        check(io_decode_en === 1'b1, "R6 on with only high base bits", 32'(io_decode_en), 1);
        cfg_write(8'h13, 8'h00);
    endtask

    task automatic t_hit();
        cfg_write(8'h11, 8'hE4);
        cfg_write(8'h10, 8'h60);
        io_addr = 16'hE460; #1;
        check(io_hit === 1'b1, "R9 first byte of window", 32'(io_hit), 1);
        io_addr = 16'hE47F; #1;
        check(io_hit === 1'b1, "R9 last byte of window", 32'(io_hit), 1);
        io_addr = 16'hE480; #1;
        check(io_hit === 1'b0, "R9 above window", 32'(io_hit), 0);
        io_addr = 16'hE45F; #1;
        check(io_hit === 1'b0, "R9 below window", 32'(io_hit), 0);
        io_addr = 16'hE460;
        cfg_write(8'h04, 8'h02);
        check(io_hit === 1'b0, "R9 no hit with decode off", 32'(io_hit), 0);
        cfg_write(8'h04, 8'h01);
    endtask

    task automatic t_irq();
        cfg_write(8'h3C, 8'hA7);
        read_expect(8'h3C, 8'hA7, "R7 line write");
        cfg_write(8'h3D, 8'h00);
        read_expect(8'h3D, 8'h04, "R7 pin read-only");
    endtask

    task automatic t_unimpl();
        logic [31:0] base_before;
        base_before = io_base;
        cfg_write(8'h06, 8'hFF); cfg_write(8'h07, 8'hFF);
        cfg_write(8'h0A, 8'hFF); cfg_write(8'h0B, 8'hFF);
        cfg_write(8'h14, 8'hFF); cfg_write(8'h3E, 8'hFF);
        read_expect(8'h06, 8'h00, "R8 status lo");
        read_expect(8'h07, 8'h00, "R8 status hi");
        read_expect(8'h08, 8'h00, "R8 revision");
        read_expect(8'h09, 8'h00, "R8 class lo");
        read_expect(8'h0A, 8'h00, "R8 class mid");
        read_expect(8'h0B, 8'h00, "R8 class hi");
        read_expect(8'h14, 8'h00, "R8 offset 14");
        read_expect(8'h3E, 8'h00, "R8 offset 3E");
        read_expect(8'hFF, 8'h00, "R8 offset FF");
        read_expect(8'h04, 8'h01, "R8 command untouched");
        read_expect(8'h3C, 8'hA7, "R8 line untouched");
        check(io_base === base_before, "R8 base untouched", io_base, base_before);
    endtask

    task automatic t_timing();
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 8'h11; cfg_wdata = 8'h33;
        #1;
        check(cfg_rdata === 8'hE4, "R10 old value before edge", 32'(cfg_rdata), 32'hE4);
        check(io_base[15:8] === 8'hE4, "R10 old base before edge", 32'(io_base[15:8]), 32'hE4);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        #1;
        check(cfg_rdata === 8'h33, "R10 new value after edge", 32'(cfg_rdata), 32'h33);
        check(io_base[15:8] === 8'h33, "R10 new base after edge", 32'(io_base[15:8]), 32'h33);
    endtask

    initial begin
        t_reset_state();
        t_identity();
        t_command();
        t_bar_bytes();
        t_decode();
        t_hit();
        t_irq();
        t_unimpl();
        t_timing();
        t_reset_state();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule